// File: doc/BRIEF.md
# Amplifier Protection and Error Reporter

This block watches over the power stage of a switching audio amplifier. Each clock it reads an unsigned die-temperature code and the output of an overcurrent comparator. It drives three active-low error lines, one each for thermal shutdown, thermal warning and overcurrent. It also raises two requests towards the power-stage control: one that turns the output stage off and one that mutes it.

The two thermal faults use hysteresis and recover on their own. Each one sets when the temperature goes above its own threshold. Both stay set until the temperature falls below a lower restore threshold. The overcurrent fault works differently: once it latches it stays latched. Only a release of the amplifier's active-low reset control or of its active-low mute control clears it. A release is the rising edge of either control. Before the latch sets, the comparator input must be high for a programmable number of consecutive clocks, so that short glitches are ignored.

Top module: `amp_guard`

## Requirements
- R1: One clock after the synchronous reset `rst` is high, `err_tsd_n`, `err_twarn_n` and `err_oc_n` read 1 (an error line is active when it reads 0), and `shutdown_req` and `mute_req` read 0.
- R2: One clock after `temp_code` is strictly above WARN_TH (default 135), `err_twarn_n` reads 0. A code equal to WARN_TH does not set the warning.
- R3: One clock after `temp_code` is strictly above SHUT_TH (default 150), `err_tsd_n` reads 0 and `shutdown_req` reads 1, and the warning is set as well. A code equal to SHUT_TH does not set the shutdown.
- R4: A thermal fault that is set stays set while `temp_code` is at or above RESTORE_TH (default 120), even when the code has dropped below the threshold that set it.
- R5: One clock after `temp_code` is strictly below RESTORE_TH, both thermal faults are clear. A code equal to RESTORE_TH keeps them.
- R6: `err_oc_n` goes to 0 and `mute_req` goes to 1 at the clock edge on which `oc_in` has been high for OC_FILT consecutive edges (default 2). A shorter high pulse has no effect.
- R7: A latched overcurrent fault stays set after `oc_in` returns low.
- R8: A latched overcurrent fault clears one clock after `ctl_rst_n` or `ctl_mute_n` goes from 0 to 1. Holding either control at 0 does not clear the fault.
- R9: If the overcurrent condition is still qualified when a release edge arrives, the fault stays set through that edge without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| temp_code | input | TEMP_W | Die temperature in degrees C, unsigned |
| oc_in | input | 1 | Overcurrent comparator output, high while current is too high |
| ctl_rst_n | input | 1 | Amplifier reset control, active low; its release clears the overcurrent fault |
| ctl_mute_n | input | 1 | Amplifier mute control, active low; its release clears the overcurrent fault |
| err_tsd_n | output | 1 | Thermal shutdown error, active low |
| err_twarn_n | output | 1 | Thermal warning error, active low |
| err_oc_n | output | 1 | Overcurrent error, active low |
| shutdown_req | output | 1 | Request to turn the output stage off |
| mute_req | output | 1 | Request to mute the output stage |

## Verification
The bench builds the block with its default parameters: an 8-bit code, thresholds 135, 150 and 120, and a two-clock glitch filter. With the 8-bit code the bench can reach both ends of the scale, 0 and 255. It can also place the code exactly on each threshold and one step to either side of it. With the two-clock filter a one-clock glitch can be compared with a pulse that qualifies. It also allows a release edge to be placed while the comparator is still qualified, which is the case that re-latches the fault.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

    // Thermal fault pair carried between the monitor and the top
    typedef struct packed {
        logic shut;
        logic warn;
    } therm_flags_t;

    // Number of control pins whose release clears the overcurrent latch
    localparam int unsigned REL_SRC_N = 2;
    localparam int unsigned REL_IDX_RESET = 0;
    localparam int unsigned REL_IDX_MUTE  = 1;

    // Hysteresis step: restore has priority, shutdown implies warning
    function automatic therm_flags_t therm_next(
        input therm_flags_t cur,
        input int unsigned  temp,
        input int unsigned  warn_th,
        input int unsigned  shut_th,
        input int unsigned  rest_th
    );
        therm_flags_t nxt;
        nxt = cur;
        if (temp < rest_th) begin
            nxt = '0;
        end else begin
            if (temp > warn_th) nxt.warn = 1'b1;
            if (temp > shut_th) begin
                nxt.shut = 1'b1;
                nxt.warn = 1'b1;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/amp_guard_thermal.sv
module amp_guard_thermal
    import amp_guard_pkg::*;
#(
    parameter int unsigned TEMP_W   = 8,
    parameter int unsigned WARN_TH  = 135,
    parameter int unsigned SHUT_TH  = 150,
    parameter int unsigned REST_TH  = 120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_code,
    output therm_flags_t      flags
);

    localparam int unsigned CODE_MAX = (1 << TEMP_W) - 1;

    int unsigned temp_u;
    assign temp_u = 32'(temp_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= therm_next(flags, temp_u, WARN_TH, SHUT_TH, REST_TH);
        end
    end

    assert_warn_set_R2: assert property (@(posedge clk) disable iff (rst)
        (temp_u > WARN_TH && temp_u >= REST_TH) |=> flags.warn);

    assert_shut_implies_warn_R3: assert property (@(posedge clk) disable iff (rst)
        flags.shut |-> flags.warn);

    assert_warn_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (flags.warn && temp_u >= REST_TH) |=> flags.warn);

    assert_restore_R5: assert property (@(posedge clk) disable iff (rst)
        (temp_u < REST_TH) |=> (!flags.warn && !flags.shut));

    initial begin
        assert_code_range_R2: assert (CODE_MAX >= SHUT_TH);
    end

endmodule

// File: rtl/amp_guard_ocfilt.sv
module amp_guard_ocfilt #(
    parameter int unsigned OC_FILT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_in,
    input  logic clr,
    output logic fault
);

    localparam int unsigned CW  = (OC_FILT > 1) ? $clog2(OC_FILT) : 1;
    localparam logic [CW-1:0] SAT = CW'(OC_FILT - 1);

    logic [CW-1:0] run_cnt;
    logic          qualified;

    // qualified on the edge that completes OC_FILT consecutive highs
    assign qualified = oc_in && (run_cnt == SAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (!oc_in) begin
            run_cnt <= '0;
        end else if (run_cnt != SAT) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // set has priority over clear, so a live fault re-latches at once
    always_ff @(posedge clk) begin
        if (rst) begin
            fault <= 1'b0;
        end else begin
            fault <= qualified | (fault & ~clr);
        end
    end

    assert_no_set_when_low_R6: assert property (@(posedge clk) disable iff (rst)
        (!fault && !oc_in) |=> !fault);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (fault && !clr) |=> fault);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (fault && clr && !oc_in) |=> !fault);

    assert_relatch_R9: assert property (@(posedge clk) disable iff (rst)
        (fault && oc_in && run_cnt == SAT) |=> fault);

endmodule

// File: rtl/amp_guard_release.sv
module amp_guard_release #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pins_n,
    output logic         any_rel
);

    logic [N-1:0] prev_q;
    logic [N-1:0] rel;

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b1;
            else     prev_q[i] <= pins_n[i];
        end

        assign rel[i] = pins_n[i] & ~prev_q[i];

        assert_release_single_R8: assert property (@(posedge clk) disable iff (rst)
            rel[i] |=> !rel[i]);
    end

    assign any_rel = |rel;

endmodule

// File: rtl/amp_guard.sv
module amp_guard
    import amp_guard_pkg::*;
#(
    parameter int unsigned TEMP_W     = 8,
    parameter int unsigned WARN_TH    = 135,
    parameter int unsigned SHUT_TH    = 150,
    parameter int unsigned RESTORE_TH = 120,
    parameter int unsigned OC_FILT    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              oc_in,
    input  logic              ctl_rst_n,
    input  logic              ctl_mute_n,
    output logic              err_tsd_n,
    output logic              err_twarn_n,
    output logic              err_oc_n,
    output logic              shutdown_req,
    output logic              mute_req
);

    therm_flags_t          tflags;
    logic                  oc_fault;
    logic                  clr_pulse;
    logic [REL_SRC_N-1:0]  ctl_pins_n;

    assign ctl_pins_n[REL_IDX_RESET] = ctl_rst_n;
    assign ctl_pins_n[REL_IDX_MUTE]  = ctl_mute_n;

    amp_guard_thermal #(
        .TEMP_W  (TEMP_W),
        .WARN_TH (WARN_TH),
        .SHUT_TH (SHUT_TH),
        .REST_TH (RESTORE_TH)
    ) u_thermal (
        .clk       (clk),
        .rst       (rst),
        .temp_code (temp_code),
        .flags     (tflags)
    );

    amp_guard_release #(
        .N (REL_SRC_N)
    ) u_release (
        .clk     (clk),
        .rst     (rst),
        .pins_n  (ctl_pins_n),
        .any_rel (clr_pulse)
    );

    amp_guard_ocfilt #(
        .OC_FILT (OC_FILT)
    ) u_ocfilt (
        .clk   (clk),
        .rst   (rst),
        .oc_in (oc_in),
        .clr   (clr_pulse),
        .fault (oc_fault)
    );

    assign err_tsd_n    = ~tflags.shut;
    assign err_twarn_n  = ~tflags.warn;
    assign err_oc_n     = ~oc_fault;
    assign shutdown_req = tflags.shut;
    assign mute_req     = oc_fault;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (err_tsd_n && err_twarn_n && err_oc_n && !shutdown_req && !mute_req));

    assert_hold_during_ctl_low_R8: assert property (@(posedge clk) disable iff (rst)
        (!err_oc_n && !ctl_rst_n && !ctl_mute_n) |=> !err_oc_n);

endmodule

// File: tb/test_amp_guard.sv
module test_amp_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] temp_code;
    logic       oc_in;
    logic       ctl_rst_n;
    logic       ctl_mute_n;
    logic       err_tsd_n, err_twarn_n, err_oc_n, shutdown_req, mute_req;

    int n_cmp = 0;
    int n_bad = 0;

    // {temperature, expected err_twarn_n, expected err_tsd_n}
    localparam logic [9:0] TVEC [NVEC] = '{
        {8'd25,  1'b1, 1'b1},   // idle
        {8'd135, 1'b1, 1'b1},   // R2 boundary, not above
        {8'd136, 1'b0, 1'b1},   // R2 warning set
        {8'd150, 1'b0, 1'b1},   // R3 boundary, not above
        {8'd151, 1'b0, 1'b0},   // R3 shutdown set
        {8'd200, 1'b0, 1'b0},
        {8'd130, 1'b0, 1'b0},   // R4 both held
        {8'd120, 1'b0, 1'b0},   // R5 boundary holds
        {8'd119, 1'b1, 1'b1},   // R5 restore
        {8'd140, 1'b0, 1'b1},
        {8'd125, 1'b0, 1'b1},   // R4 warning held
        {8'd100, 1'b1, 1'b1},
        {8'd255, 1'b0, 1'b0},   // top of scale
        {8'd0,   1'b1, 1'b1}    // bottom of scale
    };

    amp_guard i_amp_guard (
        .clk          (clk),
        .rst          (rst),
        .temp_code    (temp_code),
        .oc_in        (oc_in),
        .ctl_rst_n    (ctl_rst_n),
        .ctl_mute_n   (ctl_mute_n),
        .err_tsd_n    (err_tsd_n),
        .err_twarn_n  (err_twarn_n),
        .err_oc_n     (err_oc_n),
        .shutdown_req (shutdown_req),
        .mute_req     (mute_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // inputs change at a falling edge; one rising edge later, sample at the next falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic check_oc(input string req, input logic exp_n);
        check(req, "err_oc_n", err_oc_n, exp_n);
        check(req, "mute_req", mute_req, ~exp_n);
    endtask

    task automatic latch_oc();
        oc_in = 1'b1; step(); step();
        oc_in = 1'b0; step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; temp_code = 8'd25; oc_in = 1'b0;
        ctl_rst_n = 1'b1; ctl_mute_n = 1'b1;
        @(negedge clk); step();
        // R1 reset state
        check("R1", "err_tsd_n", err_tsd_n, 1'b1);
        check("R1", "err_twarn_n", err_twarn_n, 1'b1);
        check("R1", "err_oc_n", err_oc_n, 1'b1);
        check("R1", "shutdown_req", shutdown_req, 1'b0);
        check("R1", "mute_req", mute_req, 1'b0);
        rst = 1'b0;
        step();

        // thermal table (R2 R3 R4 R5)
        for (int i = 0; i < NVEC; i++) begin
            temp_code = TVEC[i][9:2];
            step();
            check("R2/R3/R4/R5", $sformatf("vec%0d err_twarn_n", i), err_twarn_n, TVEC[i][1]);
            check("R2/R3/R4/R5", $sformatf("vec%0d err_tsd_n", i), err_tsd_n, TVEC[i][0]);
            check("R3", $sformatf("vec%0d shutdown_req", i), shutdown_req, ~TVEC[i][0]);
        end
        temp_code = 8'd60;

        // R6: single-cycle glitch is ignored
        oc_in = 1'b1; step();
        oc_in = 1'b0; step();
        check_oc("R6", 1'b1);
        step();
        check_oc("R6", 1'b1);

        // R6: two consecutive highs latch on the second edge
        oc_in = 1'b1; step();
        check_oc("R6", 1'b1);
        step();
        check_oc("R6", 1'b0);

        // R7: sticky after the input drops
        oc_in = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            check_oc("R7", 1'b0);
        end

        // R8: holding mute low does not clear, release does
        ctl_mute_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            check_oc("R8", 1'b0);
        end
        ctl_mute_n = 1'b1; step();
        check_oc("R8", 1'b1);

        // R8: reset control release also clears
        latch_oc();
        check_oc("R7", 1'b0);
        ctl_rst_n = 1'b0; step(); step();
        check_oc("R8", 1'b0);
        ctl_rst_n = 1'b1; step();
        check_oc("R8", 1'b1);

        // R9: release while still overcurrent keeps the fault without a gap
        oc_in = 1'b1; step(); step();
        check_oc("R9", 1'b0);
        ctl_mute_n = 1'b0; step();
        check_oc("R9", 1'b0);
        ctl_mute_n = 1'b1; step();
        check_oc("R9", 1'b0);
        step();
        check_oc("R9", 1'b0);
        oc_in = 1'b0; step();
        check_oc("R7", 1'b0);

        // R1: reset mid-run with thermal and overcurrent faults active
        temp_code = 8'd180; step();
        check("R3", "err_tsd_n", err_tsd_n, 1'b0);
        rst = 1'b1; step();
        check("R1", "err_tsd_n", err_tsd_n, 1'b1);
        check("R1", "err_twarn_n", err_twarn_n, 1'b1);
        check_oc("R1", 1'b1);
        rst = 1'b0; temp_code = 8'd25; step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule